// File: doc/BRIEF.md
# 8b/10b Jitter Test Pattern Generator

This block drives the three unframed physical-layer jitter patterns of a 1000BASE-X style serial link. Each pattern is one fixed 8b/10b code-group sent again and again. Running disparity is carried from one group to the next, so every group goes out in the form that the current disparity calls for. A two-bit select chooses the pattern:

- high frequency: the line toggles every bit.
- low frequency: five bits high, then five bits low.
- mixed frequency: a ten-run sequence of short and long runs.

The block presents the current code-group on a parallel output and also shifts it out one bit per clock, first bit first. Groups follow each other with no gap while the enable is high. A status output shows the running disparity, and a strobe marks the first bit of every group.

Serialization is controlled by a two-state machine:

- `SER_IDLE`: the line rests at the idle level.
- `SER_SHIFT`: one code-group is being shifted out.

It has four transitions:

- *start*: `SER_IDLE` to `SER_SHIFT` when `en` is seen high. This loads a group.
- *reload*: `SER_SHIFT` to `SER_SHIFT` on the tenth bit when `en` is high. This loads the next group straight away.
- *stop*: `SER_SHIFT` to `SER_IDLE` on the tenth bit when `en` is low.
- *hold*: `SER_SHIFT` stays in `SER_SHIFT` on bits one to nine.

The pattern select and the disparity are both sampled only at a load. Because of this, a change of select takes effect at the next group boundary.

Top module: `jtp_gen`

## Requirements
- R1: While reset is applied and afterwards until `en` is first seen high, the outputs are as follows: `rd_pos` is 0 (negative disparity), `ser_bit` is at the idle level (0 by default), `grp_first` is 0 and `group_out` is 0.
- R2: With `mode_sel`=00 the group loaded is 1010101010 whatever the disparity. The serial line then alternates 1 and 0 every bit.
- R3: With `mode_sel`=01 the group loaded is 0011111000 when disparity is negative and 1100000111 when it is positive. The line then shows runs of five high and five low.
- R4: With `mode_sel`=10 the group loaded is 0011111010 when disparity is negative and 1100000101 when it is positive, so the form alternates every group. The line then repeats these runs: high 5, low 1, high 1, low 1, high 2, low 5, high 1, low 1, high 1, low 2.
- R5: `rd_pos` is updated at every load. It inverts when the loaded group has an unequal count of ones and zeros, and holds otherwise. Counting +1 for each one and -1 for each zero on the line since reset, the sum at every group boundary is 0 when `rd_pos`=0 and +2 when `rd_pos`=1.
- R6: `group_out[9]` is bit a and `group_out[0]` is bit j. `ser_bit` presents `group_out[9]` in the cycle after the load and the lower bits in the following nine cycles. While `en` stays high the next group's bit a follows bit j directly. `grp_first` is 1 exactly in the cycle that shows bit a.
- R7: A change of `mode_sel` in the middle of a group leaves `group_out` and the bits still to be sent unchanged. The new pattern is loaded at the next boundary, using the disparity that was in effect.
- R8: Dropping `en` in the middle of a group lets that group finish. The line then returns to the idle level, and `rd_pos` and `group_out` keep their values.
- R9: `mode_sel`=11 behaves exactly like 00 (high frequency).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Keep sending groups while high |
| mode_sel | input | 2 | Pattern select: 00 high, 01 low, 10 mixed, 11 high |
| group_out | output | 10 | Code-group being sent, bit a in bit 9 |
| ser_bit | output | 1 | Serial line, bit a first |
| grp_first | output | 1 | High in the cycle showing bit a of a group |
| rd_pos | output | 1 | Running disparity after the current group, 1 is positive |

## Verification
The bench builds the block with the default idle level of 0. This level merges with the leading zeros of the low- and mixed-frequency groups, so the first run on the line after idle is not a full pattern run. The run-length measurement therefore drops the first and last runs and compares only the runs between them. Because the group width is fixed at ten, every code form in both disparities is reachable within a few dozen cycles. The vector walk deliberately enters the low-frequency and high-frequency patterns from positive disparity, and it changes the select halfway through a group.

// File: rtl/jtp_pkg.sv
package jtp_pkg;
    localparam int CG_W = 10;

    typedef enum logic [1:0] {
        PAT_HF     = 2'b00,
        PAT_LF     = 2'b01,
        PAT_MF     = 2'b10,
        PAT_HF_ALT = 2'b11
    } pat_e;

    typedef enum logic {
        SER_IDLE  = 1'b0,
        SER_SHIFT = 1'b1
    } ser_state_e;

    // code-groups, bit a in the MSB
    localparam logic [CG_W-1:0] CG_D21_5     = 10'b1010101010;
    localparam logic [CG_W-1:0] CG_K28_7_NEG = 10'b0011111000;
    localparam logic [CG_W-1:0] CG_K28_7_POS = 10'b1100000111;
    localparam logic [CG_W-1:0] CG_K28_5_NEG = 10'b0011111010;
    localparam logic [CG_W-1:0] CG_K28_5_POS = 10'b1100000101;
endpackage

// File: rtl/jtp_cg_select.sv
module jtp_cg_select
    import jtp_pkg::*;
(
    input  logic [1:0]      pat,
    input  logic            rd_pos,
    output logic [CG_W-1:0] code,
    output logic            unbal
);
    always_comb begin
        unique case (pat_e'(pat))
            PAT_HF, PAT_HF_ALT: code = CG_D21_5;
            PAT_LF:             code = rd_pos ? CG_K28_7_POS : CG_K28_7_NEG;
            PAT_MF:             code = rd_pos ? CG_K28_5_POS : CG_K28_5_NEG;
            default:            code = CG_D21_5;
        endcase
    end

    assign unbal = ($countones(code) != (CG_W / 2));

    // every form sent lies within one pair of balance
    always_comb begin
        AST_CODE_BAL: assert (($countones(code) >= (CG_W / 2) - 1) &&
                              ($countones(code) <= (CG_W / 2) + 1)); // R5
    end
endmodule

// File: rtl/jtp_rd_track.sv
module jtp_rd_track (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic unbal,
    output logic rd_pos
);
    logic rd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rd_q <= 1'b0;
        else if (load && unbal)
            rd_q <= ~rd_q;
    end

    assign rd_pos = rd_q;

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && unbal) |=> $stable(rd_q)); // R5
    AST_RD_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (load && unbal) |=> (rd_q != $past(rd_q))); // R5
endmodule

// File: rtl/jtp_serializer.sv
module jtp_serializer
    import jtp_pkg::*;
#(
    parameter logic IDLE_BIT = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [CG_W-1:0] code,
    output logic            load,
    output logic            ser_bit,
    output logic            grp_first,
    output logic [CG_W-1:0] group_out
);
    localparam int              CNT_W    = $clog2(CG_W);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(CG_W - 1);

    ser_state_e       state_q, state_d;
    logic [CNT_W-1:0] idx_q;
    logic [CG_W-1:0]  shreg_q;
    logic [CG_W-1:0]  group_q;
    logic             first_q;
    logic             last_bit;

    assign last_bit = (state_q == SER_SHIFT) && (idx_q == LAST_IDX);

    // next state and load strobe
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            SER_IDLE: begin
                if (en) begin
                    load    = 1'b1;
                    state_d = SER_SHIFT;
                end
            end
            SER_SHIFT: begin
                if (idx_q == LAST_IDX) begin
                    if (en) load    = 1'b1;
                    else    state_d = SER_IDLE;
                end
            end
            default: state_d = SER_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= SER_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q   <= '0;
            shreg_q <= {CG_W{IDLE_BIT}};
            group_q <= '0;
            first_q <= 1'b0;
        end else begin
            first_q <= load;
            if (load) begin
                shreg_q <= code;
                group_q <= code;
                idx_q   <= '0;
            end else if (state_q == SER_SHIFT) begin
                if (last_bit) begin
                    shreg_q <= {CG_W{IDLE_BIT}};
                    idx_q   <= '0;
                end else begin
                    shreg_q <= {shreg_q[CG_W-2:0], IDLE_BIT};
                    idx_q   <= idx_q + 1'b1;
                end
            end
        end
    end

    assign ser_bit   = shreg_q[CG_W-1];
    assign grp_first = first_q;
    assign group_out = group_q;

    AST_GAPLESS: assert property (@(posedge clk) disable iff (!rst_n)
        (last_bit && en) |=> grp_first); // R6
    AST_FIRST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        grp_first |-> (ser_bit == group_out[CG_W-1])); // R6
    AST_HOLD_MID: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SER_SHIFT && !last_bit) |=> $stable(group_out)); // R7
    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (last_bit && !en) |=> (state_q == SER_IDLE)); // R8
    AST_IDLE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SER_IDLE) |-> (ser_bit == IDLE_BIT)); // R8
endmodule

// File: rtl/jtp_gen.sv
module jtp_gen
    import jtp_pkg::*;
#(
    parameter logic IDLE_BIT = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [1:0]      mode_sel,
    output logic [CG_W-1:0] group_out,
    output logic            ser_bit,
    output logic            grp_first,
    output logic            rd_pos
);
    logic [CG_W-1:0] code;
    logic            unbal;
    logic            load;

    jtp_cg_select u_sel (
        .pat    (mode_sel),
        .rd_pos (rd_pos),
        .code   (code),
        .unbal  (unbal)
    );

    jtp_rd_track u_rd (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .unbal  (unbal),
        .rd_pos (rd_pos)
    );

    jtp_serializer #(.IDLE_BIT(IDLE_BIT)) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .code      (code),
        .load      (load),
        .ser_bit   (ser_bit),
        .grp_first (grp_first),
        .group_out (group_out)
    );

    AST_MF_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
        (load && mode_sel == PAT_MF) |=> (rd_pos != $past(rd_pos))); // R4
    AST_HF_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        (load && mode_sel[0] == mode_sel[1]) |=> (group_out == CG_D21_5)); // R2
endmodule

// File: tb/sim_jtp_gen.sv
module sim_jtp_gen;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [1:0] mode;
        logic [9:0] code;
        logic       rd;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t TAB [NV] = '{
        '{2'b00, 10'b1010101010, 1'b0},
        '{2'b10, 10'b0011111010, 1'b1},
        '{2'b10, 10'b1100000101, 1'b0},
        '{2'b10, 10'b0011111010, 1'b1},
        '{2'b01, 10'b1100000111, 1'b1},
        '{2'b00, 10'b1010101010, 1'b1},
        '{2'b10, 10'b1100000101, 1'b0},
        '{2'b01, 10'b0011111000, 1'b0},
        '{2'b11, 10'b1010101010, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic [9:0] group_out;
    logic       ser_bit, grp_first, rd_pos;

    int n_chk  = 0;
    int n_fail = 0;
    int cum    = 0;
    logic [79:0] cap;

    always #(CLK_PERIOD / 2) clk = ~clk;

    jtp_gen u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .mode_sel(mode_sel),
        .group_out(group_out), .ser_bit(ser_bit),
        .grp_first(grp_first), .rd_pos(rd_pos)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [1:0] m);
        case (m)
            2'b00:   return "R2";
            2'b01:   return "R3";
            2'b10:   return "R4";
            default: return "R9";
        endcase
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_check(input string req, input logic [9:0] g, input logic rd);
        chk({req, " idle line"}, ser_bit, 1'b0);
        chk({req, " no strobe"}, grp_first, 1'b0);
        chk({req, " rd held"}, rd_pos, rd);
        chk({req, " group held"}, group_out, g);
    endtask

    // capture 70 bits, then measure the inner runs
    task automatic run_test(input logic [1:0] m);
        int len [80];
        logic lvl [80];
        int nr;
        int exp_l;
        logic exp_v;
        @(negedge clk); rst_n = 1'b0; en = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R1 rd after reset", rd_pos, 1'b0);
        mode_sel = m; en = 1'b1;
        for (int b = 0; b < 70; b++) begin
            tick();
            cap[b] = ser_bit;
            if (b == 69) en = 1'b0;
        end
        nr = 0;
        len[0] = 1; lvl[0] = cap[0];
        for (int b = 1; b < 70; b++) begin
            if (cap[b] == cap[b-1]) len[nr]++;
            else begin nr++; len[nr] = 1; lvl[nr] = cap[b]; end
        end
        for (int r = 1; r < nr; r++) begin
            if (m == 2'b10) begin
                case ((r - 1) % 10)
                    0: exp_l = 5; 1: exp_l = 1; 2: exp_l = 1; 3: exp_l = 1; 4: exp_l = 2;
                    5: exp_l = 5; 6: exp_l = 1; 7: exp_l = 1; 8: exp_l = 1; default: exp_l = 2;
                endcase
                exp_v = ((r - 1) % 2 == 0);
            end else if (m == 2'b01) begin
                exp_l = 5; exp_v = ((r - 1) % 2 == 0);
            end else begin
                exp_l = 1; exp_v = ((r - 1) % 2 == 1);
            end
            chk({tag_of(m), " run length"}, len[r], exp_l);
            chk({tag_of(m), " run level"}, lvl[r], exp_v);
        end
        tick();
        chk("R8 idle after run", ser_bit, 1'b0);
        chk("R5 rd after seven groups", rd_pos, (m == 2'b10) ? 1'b1 : 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        idle_check("R1 in reset", 10'h0, 1'b0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        idle_check("R1 before enable", 10'h0, 1'b0);

        // vector walk with mid-group select changes
        en = 1'b1; mode_sel = TAB[0].mode;
        for (int i = 0; i < NV; i++) begin
            tick();
            chk({tag_of(TAB[i].mode), " group"}, group_out, TAB[i].code);
            chk("R6 strobe on bit a", grp_first, 1'b1);
            chk("R6 bit a first", ser_bit, TAB[i].code[9]);
            chk("R5 rd after load", rd_pos, TAB[i].rd);
            cum += ser_bit ? 1 : -1;
            for (int k = 1; k < 10; k++) begin
                tick();
                chk("R6 serial order", ser_bit, TAB[i].code[9-k]);
                if (k == 1) chk("R6 strobe single", grp_first, 1'b0);
                cum += ser_bit ? 1 : -1;
                if (k == 5 && i < NV - 1) mode_sel = TAB[i+1].mode;
                if (k == 9) begin
                    chk("R7 group held across select change", group_out, TAB[i].code);
                    chk("R5 disparity bound", (cum == 0 || cum == 2), 1'b1);
                    chk("R5 disparity matches status", (cum == 2), rd_pos);
                    if (i == NV - 1) en = 1'b0;
                end
            end
        end
        tick();
        idle_check("R8 stop at boundary", 10'b1010101010, 1'b0);
        repeat (3) tick();
        idle_check("R8 stays idle", 10'b1010101010, 1'b0);

        // enable dropped mid-group
        @(negedge clk); en = 1'b1; mode_sel = 2'b01;
        tick();
        chk("R3 group", group_out, 10'b0011111000);
        for (int k = 1; k < 10; k++) begin
            tick();
            if (k == 3) en = 1'b0;
            if (k >= 4) chk("R8 group completes", ser_bit, 10'b0011111000 >> (9 - k) & 1);
        end
        tick();
        idle_check("R8 after drop", 10'b0011111000, 1'b0);

        // run lengths per pattern
        run_test(2'b10);
        run_test(2'b01);
        run_test(2'b00);
        run_test(2'b11);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule